// File: doc/BRIEF.md
# Receive Buffer Low-Water Switcher

This block follows how much room is left in the receive buffer area currently in use, and decides whether the next packet may still start there. A remaining-space counter, counted in 16-bit words, is loaded from the word count that the descriptor fetcher has just read. It then counts down as the packet writer stores data: one per 16-bit word in 16-bit mode, or two per 32-bit long word in 32-bit mode. The counter stops at zero.

A programmable low-water mark acts as a false bottom in the buffer area. After reset it holds 0x2F8 (760 words, a full-size frame rounded to a long word). Only at the end-of-packet strobe does the block compare the updated remaining count with this mark. If the count is strictly below the mark, the block raises a one-cycle switch request. The descriptor fetcher then supplies a fresh buffer area before the next packet is stored, so a packet is never split across two buffer areas. In 32-bit mode, bit 0 of the mark is taken as zero so that it lines up with long-word counts. In 16-bit mode, 759 words is the usual setting. For one packet per buffer, the mark should sit at least one word (16-bit mode) or one long word (32-bit mode) below the buffer size.

Top module: `rxb_lowwater`

## Requirements
- R1: After reset, thr_o reads 0x2F8, remain_o reads 0 and switch_req_o is 0.
- R2: A cycle with thr_wr_i high stores thr_wdata_i. In 16-bit mode (mode32_i=0), thr_o shows the stored value unchanged from the next cycle on.
- R3: While mode32_i=1, bit 0 of thr_o reads 0 and the other bits match the stored value.
- R4: A cycle with load_i high sets remain_o to {load_hi_i, load_lo_i} on the next cycle. This holds even if word_i is also high.
- R5: A cycle with word_i high and load_i low lowers remain_o by 1 when mode32_i=0, or by 2 when mode32_i=1.
- R6: A decrement never wraps. A step larger than the remaining count leaves remain_o at 0.
- R7: switch_req_o is high only in the cycle right after a cycle with eop_i high.
- R8: In the cycle after eop_i, switch_req_o is 1 exactly when the remaining count, after that cycle's load or decrement, is strictly below thr_o. An equal count gives 0.
- R9: With load_i and word_i both low, remain_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode32_i | input | 1 | 1: 32-bit data path, 0: 16-bit |
| thr_wr_i | input | 1 | Write strobe for the low-water mark |
| thr_wdata_i | input | 16 | New low-water mark in words |
| load_i | input | 1 | Reload the remaining count |
| load_lo_i | input | 16 | Low half of the reload word count |
| load_hi_i | input | 16 | High half of the reload word count |
| word_i | input | 1 | One storage unit written this cycle |
| eop_i | input | 1 | End-of-packet strobe |
| remain_o | output | 32 | Remaining words in the current buffer area |
| thr_o | output | 16 | Effective low-water mark |
| switch_req_o | output | 1 | One-cycle request for a new buffer area |

## Verification
The comparison is swept over counts from three below to three above the mark, in both modes and for an even and an odd stored mark. This separates strict from non-strict comparison and shows whether bit 0 is masked in 32-bit mode. Word streams from odd and even loads run past zero, which tells the two step sizes apart and exposes any wraparound. An end-of-packet strobe placed on the same cycle as the final word shows whether the decision uses the updated count or the stale one. A strobe on the same cycle as a reload, and words sent without any strobe, test the load priority and the rule that only the strobe can raise a request.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned THR_W   = 16;
  localparam logic [15:0] THR_RST = 16'h02F8;
endpackage

// File: rtl/rxb_thr_reg.sv
module rxb_thr_reg #(
  parameter int unsigned      THR_W   = 16,
  parameter logic [THR_W-1:0] THR_RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [THR_W-1:0] wdata_i,
  input  logic             mode32_i,
  output logic [THR_W-1:0] thr_o
);
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_q <= THR_RST;
    else if (wr_i) thr_q <= wdata_i;
  end

  // long-word counts are even: drop bit 0 so the compare lines up
  always_comb begin
    thr_o    = thr_q;
    thr_o[0] = thr_q[0] & ~mode32_i;
  end
endmodule

// File: rtl/rxb_word_ctr.sv
module rxb_word_ctr #(
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode32_i,
  input  logic              load_i,
  input  logic [HALF_W-1:0] load_lo_i,
  input  logic [HALF_W-1:0] load_hi_i,
  input  logic              word_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q, step, dec;

  always_comb begin
    step = mode32_i ? CNT_W'(2) : CNT_W'(1);
    dec  = (cnt_q < step) ? '0 : cnt_q - step;
    if (load_i)      cnt_nxt_o = {load_hi_i, load_lo_i};
    else if (word_i) cnt_nxt_o = dec;
    else             cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rxb_switch_ctl.sv
module rxb_switch_ctl #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned THR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eop_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             req_o
);
  logic [CNT_W-1:0] thr_ext;
  logic             below;
  logic             req_q;

  assign thr_ext = {{(CNT_W-THR_W){1'b0}}, thr_i};
  assign below   = cnt_nxt_i < thr_ext;

  // decision only at the packet boundary, on the updated count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= eop_i & below;
  end

  assign req_o = req_q;
endmodule

// File: rtl/rxb_lowwater.sv
module rxb_lowwater
  import rxb_pkg::*;
#(
  parameter int unsigned  CNT_W  = rxb_pkg::CNT_W,
  parameter int unsigned  THR_W  = rxb_pkg::THR_W,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode32_i,
  input  logic              thr_wr_i,
  input  logic [THR_W-1:0]  thr_wdata_i,
  input  logic              load_i,
  input  logic [HALF_W-1:0] load_lo_i,
  input  logic [HALF_W-1:0] load_hi_i,
  input  logic              word_i,
  input  logic              eop_i,
  output logic [CNT_W-1:0]  remain_o,
  output logic [THR_W-1:0]  thr_o,
  output logic              switch_req_o
);
  logic [CNT_W-1:0] cnt_nxt;

  rxb_thr_reg #(
    .THR_W  (THR_W),
    .THR_RST(THR_W'(THR_RST))
  ) u_thr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (thr_wr_i),
    .wdata_i (thr_wdata_i),
    .mode32_i(mode32_i),
    .thr_o   (thr_o)
  );

  rxb_word_ctr #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode32_i (mode32_i),
    .load_i   (load_i),
    .load_lo_i(load_lo_i),
    .load_hi_i(load_hi_i),
    .word_i   (word_i),
    .cnt_o    (remain_o),
    .cnt_nxt_o(cnt_nxt)
  );

  rxb_switch_ctl #(
    .CNT_W(CNT_W),
    .THR_W(THR_W)
  ) u_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eop_i    (eop_i),
    .cnt_nxt_i(cnt_nxt),
    .thr_i    (thr_o),
    .req_o    (switch_req_o)
  );
endmodule

// File: rtl/rxb_lowwater_chk.sv
module rxb_lowwater_chk #(
  parameter int unsigned  CNT_W  = 32,
  parameter int unsigned  THR_W  = 16,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode32_i,
  input logic              load_i,
  input logic [HALF_W-1:0] load_lo_i,
  input logic [HALF_W-1:0] load_hi_i,
  input logic              word_i,
  input logic              eop_i,
  input logic [CNT_W-1:0]  remain_o,
  input logic [THR_W-1:0]  thr_o,
  input logic              switch_req_o
);
  p_bit0_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode32_i |-> (thr_o[0] == 1'b0));

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (remain_o == $past({load_hi_i, load_lo_i})));

  p_dec16_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && word_i && !mode32_i && remain_o != '0)
      |=> (remain_o == $past(remain_o) - CNT_W'(1)));

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && word_i && remain_o < CNT_W'(2)
      && (mode32_i || remain_o == '0)) |=> (remain_o == '0));

  p_req_after_eop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eop_i |=> !switch_req_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !word_i) |=> $stable(remain_o));
endmodule

bind rxb_lowwater rxb_lowwater_chk #(
  .CNT_W(CNT_W),
  .THR_W(THR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode32_i    (mode32_i),
  .load_i      (load_i),
  .load_lo_i   (load_lo_i),
  .load_hi_i   (load_hi_i),
  .word_i      (word_i),
  .eop_i       (eop_i),
  .remain_o    (remain_o),
  .thr_o       (thr_o),
  .switch_req_o(switch_req_o)
);

// File: tb/rxb_lowwater_tb_top.sv
`timescale 1ns/1ps
module rxb_lowwater_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode32_i = 1'b0;
  logic        thr_wr_i = 1'b0;
  logic [15:0] thr_wdata_i = '0;
  logic        load_i = 1'b0;
  logic [15:0] load_lo_i = '0;
  logic [15:0] load_hi_i = '0;
  logic        word_i = 1'b0;
  logic        eop_i = 1'b0;
  logic [31:0] remain_o;
  logic [15:0] thr_o;
  logic        switch_req_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  rxb_lowwater dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic do_load(input logic [31:0] v);
    load_i = 1'b1; {load_hi_i, load_lo_i} = v;
    tick();
    load_i = 1'b0;
  endtask

  task automatic do_thr(input logic [15:0] v);
    thr_wr_i = 1'b1; thr_wdata_i = v;
    tick();
    thr_wr_i = 1'b0;
  endtask

  function automatic logic [31:0] eff_thr(input logic [15:0] t, input logic m32);
    return m32 ? {16'h0, t[15:1], 1'b0} : {16'h0, t};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_cnt;
    logic [31:0] et;
    tick();
    // R1 reset state
    chk("R1 thr", {16'h0, thr_o}, 32'h2F8);
    chk("R1 remain", remain_o, 32'h0);
    chk("R1 req", {31'h0, switch_req_o}, 32'h0);
    rst_ni = 1'b1;
    tick();

    // R2 / R3 threshold write and masking
    do_thr(16'h02F7);
    chk("R2 thr16", {16'h0, thr_o}, 32'h2F7);
    mode32_i = 1'b1; tick();
    chk("R3 thr32", {16'h0, thr_o}, 32'h2F6);
    mode32_i = 1'b0; tick();
    chk("R2 thr16 back", {16'h0, thr_o}, 32'h2F7);

    // R4 load wide value, load beats word
    do_load(32'h1234_5678);
    chk("R4 load", remain_o, 32'h1234_5678);
    word_i = 1'b1; do_load(32'h0001_0003); word_i = 1'b0;
    chk("R4 load priority", remain_o, 32'h0001_0003);
    // R9 idle hold
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 hold", remain_o, 32'h0001_0003);
    end

    // R5 / R6 word streams past zero, both modes, odd and even loads
    for (int m = 0; m < 2; m++) begin
      for (int ld = 6; ld < 8; ld++) begin
        mode32_i = m[0];
        do_load(32'(ld));
        exp_cnt = 32'(ld);
        for (int k = 0; k < 9; k++) begin
          word_i = 1'b1; tick(); word_i = 1'b0;
          exp_cnt = (exp_cnt < 32'(m + 1)) ? 32'h0 : exp_cnt - 32'(m + 1);
          chk(exp_cnt == 0 ? "R6 no wrap" : "R5 step", remain_o, exp_cnt);
          // R7 no request without end of packet, even below the mark
          chk("R7 no eop", {31'h0, switch_req_o}, 32'h0);
        end
      end
    end

    // R8 sweep around the mark
    for (int m = 0; m < 2; m++) begin
      for (int t = 18; t < 20; t++) begin
        mode32_i = m[0];
        do_thr(16'(t));
        et = eff_thr(16'(t), m[0]);
        chk("R3 mask", {16'h0, thr_o}, et);
        for (int off = -3; off <= 3; off++) begin
          do_load(et + 32'(off));
          eop_i = 1'b1; tick(); eop_i = 1'b0;
          chk("R8 compare", {31'h0, switch_req_o}, {31'h0, (off < 0)});
          tick();
          chk("R8 pulse end", {31'h0, switch_req_o}, 32'h0);
        end
      end
    end

    // R8 decision uses count after the final word
    mode32_i = 1'b0;
    do_thr(16'd19);
    do_load(32'd20);
    word_i = 1'b1; eop_i = 1'b1; tick();
    chk("R8 eq after word", {31'h0, switch_req_o}, 32'h0);
    tick(); word_i = 1'b0; eop_i = 1'b0;
    chk("R8 below after word", {31'h0, switch_req_o}, 32'h1);
    chk("R5 remain", remain_o, 32'd18);
    // R8 eop with reload: decision uses loaded value
    load_i = 1'b1; {load_hi_i, load_lo_i} = 32'd100; eop_i = 1'b1; tick();
    load_i = 1'b0; eop_i = 1'b0;
    chk("R8 with load", {31'h0, switch_req_o}, 32'h0);
    chk("R4 with eop", remain_o, 32'd100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule